// File: doc/BRIEF.md
# Parity-Matched Shaped Requantizer Stage

This block is one stage of a chain that shortens a wide digital control word by one bit per stage without feeding a deterministic pattern into the next stage. Each cycle it takes a signed integer and a small random selector. It picks a small correction whose parity equals the parity of the integer, so the sum of the two is always even. It then halves that sum exactly and passes the result on as a word that is one bit narrower.

The choice of correction depends on three things: the integer's least significant bit, the selector, and the running total of all past corrections. The table is built to pull that total back toward a small window, which shapes the correction sequence to first order. It also spreads the choices so that low powers of both the correction and its running total carry no discrete tones. A stage further up the chain, or a free-running generator, supplies the selector; this block does not create it.

The correction and the halved word are combinational functions of the present inputs and the stored total. The total is the only state. It advances on rising clock edges when the enable is high, and it wraps modulo 2^SUM_W.

Top module: `qstage`

## Requirements
- R1: The correction output `corr` (3-bit two's complement) always has the same least significant bit as `x_in`.
- R2: `corr` only takes values in {-3,-2,-1,0,1,2,3}; the code -4 never appears.
- R3: For even `x_in`, with t the stored total and r the selector: r=2 gives 0 if 0<=t<=3, otherwise -2. r=1 gives -2 if 0<=t<=5, otherwise 0. r=0 gives +2 if t is 0 or 1, -2 if t is 2 or 3, otherwise 0. r=-1 gives +2 if 0<=t<=5, otherwise 0. r=-2 gives 0 if 0<=t<=3, otherwise +2.
- R4: For odd `x_in`: r=2 gives -3 if 0<=t<=3, otherwise -1. r=1 gives -3 if t=0, +1 if 1<=t<=3, otherwise -1. r=0 gives -1 if t>=0, otherwise +1. r=-1 gives +3 if t=0, -1 if 1<=t<=3, otherwise +1. r=-2 gives +3 if 0<=t<=3, otherwise +1.
- R5: The selector `sel` is 3-bit two's complement. The codes 3 and -3 select the r=2 and r=-2 rows, and the code -4 selects the r=0 row.
- R6: `x_next` equals (`x_in` + `corr`)/2 exactly, taken to W-1 bits. This holds for any `x_in` in [-2^(W-1)+4, 2^(W-1)-4].
- R7: On a rising edge with `en` high and `rst` low, the stored total becomes the old total plus `corr`, wrapped to SUM_W bits.
- R8: On a rising edge with `en` low and `rst` low, the stored total keeps its value.
- R9: A rising edge with `rst` high clears the stored total to 0, whatever the value of `en`.
- R10: The sum `x_in` + `corr` always has a zero least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high clear of the stored total |
| en | input | 1 | Advance the stored total on this edge |
| x_in | input | W | Signed integer to requantize |
| sel | input | 3 | Signed random selector, nominal range -2..2 |
| corr | output | 3 | Signed correction applied this cycle |
| x_next | output | W-1 | Signed halved value for the next stage |

## Verification
The bench targets the range edges of the stored total. These are t equal to -1, 0, 1, 3, 4, 5 and 6, where a rule switches from one branch to the next. An off-by-one compare would show up there as a correction of the wrong sign or magnitude, and the total would drift away from the bench's own model. Selector codes outside -2..2 are applied to catch a decoder that lets them fall into a default of zero or pass garbage. Long stretches with the enable low check that the total holds while the selector keeps changing. Inputs near both ends of the allowed range catch a halving step that drops the sign or shifts logically.

// File: rtl/qstage.sv
module qstage #(
  parameter int W     = 16,
  parameter int SUM_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x_in,
  input  logic signed [2:0]   sel,
  output logic signed [2:0]   corr,
  output logic signed [W-2:0] x_next
);

  logic signed [SUM_W-1:0] tsum;
  logic signed [W:0]       wide_sum;

  logic in03, in05, in13, is0, nonneg;
  assign nonneg = (tsum >= 0);
  assign is0    = (tsum == 0);
  assign in03   = nonneg && (tsum <= 3);
  assign in05   = nonneg && (tsum <= 5);
  assign in13   = (tsum >= 1) && (tsum <= 3);

  always_comb begin
    corr = 3'sd0;
    if (!x_in[0]) begin
      case (sel)
        3'sd2, 3'sd3:   corr = in03 ? 3'sd0 : -3'sd2;
        3'sd1:          corr = in05 ? -3'sd2 : 3'sd0;
        -3'sd1:         corr = in05 ? 3'sd2 : 3'sd0;
        -3'sd2, -3'sd3: corr = in03 ? 3'sd0 : 3'sd2;
        default:        corr = (nonneg && tsum <= 1) ? 3'sd2 :
                               in03 ? -3'sd2 : 3'sd0;
      endcase
    end else begin
      case (sel)
        3'sd2, 3'sd3:   corr = in03 ? -3'sd3 : -3'sd1;
        3'sd1:          corr = is0 ? -3'sd3 : (in13 ? 3'sd1 : -3'sd1);
        -3'sd1:         corr = is0 ? 3'sd3 : (in13 ? -3'sd1 : 3'sd1);
        -3'sd2, -3'sd3: corr = in03 ? 3'sd3 : 3'sd1;
        default:        corr = nonneg ? -3'sd1 : 3'sd1;
      endcase
    end
  end

  assign wide_sum = {x_in[W-1], x_in} + {{(W-2){corr[2]}}, corr};
  assign x_next   = wide_sum[W-1:1];

  always_ff @(posedge clk) begin
    if (rst)     tsum <= '0;
    else if (en) tsum <= tsum + {{(SUM_W-3){corr[2]}}, corr};
  end

  p_parity_r1: assert property (@(posedge clk) disable iff (rst)
    corr[0] == x_in[0]);
  p_corr_range_r2: assert property (@(posedge clk) disable iff (rst)
    corr != -3'sd4);
  p_even_sum_r10: assert property (@(posedge clk) disable iff (rst)
    wide_sum[0] == 1'b0);
  p_accumulate_r7: assert property (@(posedge clk) disable iff (rst)
    en |=> tsum == SUM_W'($past(tsum) + SUM_W'($past(corr))));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(tsum));
  p_clear_r9: assert property (@(posedge clk) rst |=> tsum == '0);

endmodule

// File: tb/qstage_tb.sv
module qstage_tb;
  localparam int W = 16;
  localparam int SUM_W = 6;

  logic clk = 0, rst = 1, en = 0;
  logic signed [W-1:0] x_in = '0;
  logic signed [2:0]   sel = '0;
  logic signed [2:0]   corr;
  logic signed [W-2:0] x_next;

  int checks = 0, fails = 0;
  logic signed [SUM_W-1:0] mt;

  always #5 clk = ~clk;

  qstage #(.W(W), .SUM_W(SUM_W)) u_dut (.*);

  function automatic int ref_corr(input bit odd, input int r, input int t);
    int rr = (r == 3) ? 2 : (r == -3) ? -2 : (r == -4) ? 0 : r;
    bit a03 = t >= 0 && t <= 3, a05 = t >= 0 && t <= 5, a13 = t >= 1 && t <= 3;
    if (!odd) begin
      case (rr)
        2:  return a03 ? 0 : -2;
        1:  return a05 ? -2 : 0;
        -1: return a05 ? 2 : 0;
        -2: return a03 ? 0 : 2;
        default: return (t == 0 || t == 1) ? 2 : a03 ? -2 : 0;
      endcase
    end
    case (rr)
      2:  return a03 ? -3 : -1;
      1:  return t == 0 ? -3 : a13 ? 1 : -1;
      -1: return t == 0 ? 3 : a13 ? -1 : 1;
      -2: return a03 ? 3 : 1;
      default: return t >= 0 ? -1 : 1;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic signed [W-1:0] x, input int r, input bit e);
    int ec, en_v;
    @(negedge clk);
    x_in = x; sel = r[2:0]; en = e;
    #2;
    ec = ref_corr(x[0], int'(sel), int'(mt));
    en_v = (int'(x) + ec) >>> 1;
    chk(x[0] ? "R4 odd corr" : "R3 even corr", int'(corr), ec);
    chk("R6 halved value", int'(x_next), en_v);
    if (corr[0] != x[0]) chk("R1 parity", int'(corr[0]), int'(x[0]));
    if (e) mt = mt + SUM_W'(ec);
  endtask

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    mt = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    // reset state: t=0, even, r=0 -> +2 (R9, R3)
    step(16'sd100, 0, 0);
    // R5 out-of-range selector codes
    step(16'sd7, 3, 0); step(16'sd7, -3, 0); step(16'sd7, -4, 0);
    step(16'sd8, 3, 0); step(16'sd8, -4, 0);
    // R8 hold: en low, varied selectors, t must remain 0
    for (int i = 0; i < 20; i++) step(16'(i * 3), int'($urandom_range(4)) - 2, 0);
    // push t upward to walk boundaries (R7)
    for (int i = 0; i < 6; i++) step(16'sd10, -1, 1);
    for (int i = 0; i < 8; i++) step(16'sd11, -2, 1);
    for (int i = 0; i < 8; i++) step(16'sd12, 1, 1);
    // extreme inputs (R6)
    step(16'sd32763, 2, 1); step(-16'sd32764, -2, 1);
    step(16'sd32762, -1, 1); step(-16'sd32763, 1, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int xv = int'($urandom_range(65528)) - 32764;
      step(16'(xv), int'($urandom_range(7)) - 4, $urandom_range(9) != 0);
    end
    // R9: reset while enabled clears total
    @(negedge clk); rst = 1; en = 1;
    @(negedge clk); rst = 0; en = 0; mt = '0;
    step(16'sd2, 0, 0);  // t=0, even, r=0 -> +2
    step(16'sd3, 1, 0);  // t=0, odd,  r=1 -> -3
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule